// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block watches three comparator match pulses and walks a four-state sequencer toward a final state. It does not contain the comparators. Reaching the final state raises a one-cycle trigger. The trigger does two jobs. It raises a breakpoint request toward the CPU, either as a debug-mode request or as a software-interrupt request. It also bounds a trace session into a small on-chip buffer that records a captured bus word each cycle.

Three device-mode inputs decide which functions are allowed:

- debug mode enabled
- debug mode active
- device secure

A registered qualifier turns these inputs into four allow flags: match, breakpoint, tag and trace. All internal logic uses these flags.

Software programs the block through a small register-style port. It uses this port to arm the block, pick the trace alignment and fill the next-state table. Once the block has disarmed, software drains the trace buffer through a sequential read port, oldest word first.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset the block is disarmed, `state` is 0, `trace_cnt` is 0, and `trig`, `bkpt_req`, `swi_req` and `rd_valid` are low.
- R2: While armed and with matching allowed, the next state comes from a table entry for the current state. The lowest-numbered asserted match bit is chosen, so match0 wins over match1 and match1 wins over match2. The table entry for state s (s = 0..2) is written with `cfg_sel` = s+1. In that entry, `cfg_data[1:0]` is the target for match0, `[3:2]` the target for match1 and `[5:4]` the target for match2.
- R3: State 3 is the final state. Entering it raises `trig` for exactly one cycle, in the same cycle that `state` first reads 3. While still armed, no match moves the sequencer out of state 3.
- R4: While disarmed, `state` is 0 one cycle later and stays there; matches are ignored.
- R5: In end-aligned mode (`cfg_data[1]`=1 at arm time), `bus_word` is captured in every armed cycle up to and including the cycle whose match enters the final state. The buffer keeps the newest 16 words, and `armed` clears on the trigger.
- R6: In begin-aligned mode (`cfg_data[1]`=0), capture starts in the first cycle spent in the final state. Capture runs for 16 cycles, after which `armed` clears.
- R7: While disarmed, each `rd_en` cycle returns the next stored word, oldest first, on `rd_data`, with `rd_valid` high one cycle later. Read requests beyond `trace_cnt` produce no `rd_valid`.
- R8: `mode_allow` = {trace, tag, breakpoint, match}, one cycle after the mode inputs change. The value is 4'b0111 when `secure`=1, 4'b0000 when enabled and active and not secure, and 4'b1111 otherwise.
- R9: On entering the final state with breakpoints allowed, a one-cycle pulse is raised together with `trig`. It is `bkpt_req` if `dbg_en`=1 and `swi_req` if `dbg_en`=0; both never rise together.
- R10: When `secure`=1, nothing is captured and `trace_cnt` stays 0, while the trigger and breakpoint still occur.
- R11: Debug mode becoming active while armed leaves the block armed, and the sequencer does not move while matching is disallowed.
- R12: Writing `cfg_sel`=0 with `cfg_data[0]`=1 while disarmed arms the block and clears `trace_cnt` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Debug mode enabled |
| dbg_act | input | 1 | Debug mode active |
| secure | input | 1 | Device secured |
| match_i | input | NMATCH | Comparator match pulses, bit 0 highest priority |
| bus_word | input | DW | Captured bus word for tracing |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 = control (bit0 arm, bit1 end-align), 1..3 = table entry for state 0..2 |
| cfg_data | input | 2*NMATCH | Configuration write data |
| rd_en | input | 1 | Trace read request (honoured while disarmed) |
| rd_data | output | DW | Trace read data |
| rd_valid | output | 1 | Read data valid |
| trace_cnt | output | $clog2(DEPTH)+1 | Number of stored trace words |
| armed | output | 1 | Block armed |
| state | output | 2 | Sequencer state |
| trig | output | 1 | Final-state trigger pulse |
| bkpt_req | output | 1 | Debug-mode breakpoint request pulse |
| swi_req | output | 1 | Software-interrupt breakpoint request pulse |
| mode_allow | output | 4 | Registered allow flags {trace, tag, bkpt, match} |

## Verification
The bench drives simultaneous matches to catch a reversed priority. A design with the priority reversed would land in state 0 instead of the final state. It runs more than 16 armed cycles in end-aligned mode. A buffer that stopped when full, or that read out from the wrong point, would return the first words instead of the newest ones. In begin-aligned mode it fires a match while in the final state. A sequencer that still took transitions there would leave state 3 and cut the capture short. The bench also raises debug-active mid-session and then asserts secure. These steps expose a qualifier that drops the arm flag, lets matches through, or records trace data while secured.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int NSTATE = 4;
  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_FINAL = 2'd3;
  localparam logic [1:0] SEL_CTRL = 2'd0;

  typedef struct packed {
    logic trace;
    logic tag;
    logic bkpt;
    logic match;
  } allow_t;
endpackage

// File: rtl/dbg_mode_qual.sv
module dbg_mode_qual
  import dbg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   dbg_en,
  input  logic   dbg_act,
  input  logic   secure,
  output allow_t allow_q
);
  allow_t allow_d;

  always_comb begin
    if (secure)                 allow_d = '{trace: 1'b0, tag: 1'b1, bkpt: 1'b1, match: 1'b1};
    else if (dbg_en && dbg_act) allow_d = '0;
    else                        allow_d = '{trace: 1'b1, tag: 1'b1, bkpt: 1'b1, match: 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) allow_q <= '0;
    else     allow_q <= allow_d;
  end

  // R10
  secure_no_trace_chk: assert property (@(posedge clk) disable iff (rst)
    secure |=> !allow_q.trace);
  // R8
  active_blocks_all_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_en && dbg_act && !secure) |=> (allow_q == '0));
endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_pkg::*;
#(
  parameter int NMATCH = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      armed,
  input  logic                      match_en,
  input  logic [NMATCH-1:0]         match_i,
  input  logic                      tbl_we,
  input  logic [1:0]                tbl_idx,
  input  logic [NMATCH-1:0][1:0]    tbl_data,
  output logic [1:0]                state_q,
  output logic                      enter_final,
  output logic                      trig_q
);
  logic [NMATCH-1:0][1:0] tbl [NSTATE];
  logic [1:0] nxt;
  logic       hit;
  logic       adv;

  for (genvar s = 0; s < NSTATE; s++) begin : g_tbl
    if (s == int'(ST_FINAL)) begin : g_final
      assign tbl[s] = '0;
    end else begin : g_entry
      always_ff @(posedge clk) begin
        if (rst)                                  tbl[s] <= '0;
        else if (tbl_we && tbl_idx == 2'(s))      tbl[s] <= tbl_data;
      end
    end
  end

  always_comb begin
    hit = 1'b0;
    nxt = state_q;
    for (int i = NMATCH - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit = 1'b1;
        nxt = tbl[state_q][i];
      end
    end
  end

  assign adv         = armed && match_en && (state_q != ST_FINAL) && hit;
  assign enter_final = adv && (nxt == ST_FINAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= enter_final;
      if (!armed)   state_q <= ST_IDLE;
      else if (adv) state_q <= nxt;
    end
  end

  // R4
  disarm_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (state_q == ST_IDLE));
  // R3
  final_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && state_q == ST_FINAL) |=> (state_q == ST_FINAL));
  // R3
  trig_in_final_chk: assert property (@(posedge clk) disable iff (rst)
    trig_q |-> (state_q == ST_FINAL && !$past(state_q == ST_FINAL)));
endmodule

// File: rtl/dbg_trace_buf.sv
module dbg_trace_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cap,
  input  logic [DW-1:0] wdata,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data_q,
  output logic          rd_valid_q,
  output logic [CW-1:0] cnt_q
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q;
  logic [CW-1:0] rd_idx_q;
  logic [AW-1:0] raddr;
  logic          rd_go;

  assign rd_go = rd_req && (rd_idx_q < cnt_q);
  assign raddr = wptr_q - cnt_q[AW-1:0] + rd_idx_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (cap) mem[wptr_q] <= wdata;
    if (rd_go) rd_data_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr_q   <= '0;
      cnt_q    <= '0;
      rd_idx_q <= '0;
    end else begin
      if (cap) begin
        wptr_q <= wptr_q + 1'b1;
        if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
      end
      if (rd_go) rd_idx_q <= rd_idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid_q <= 1'b0;
    else     rd_valid_q <= rd_go;
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  // R12
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_pkg::*;
#(
  parameter int DW     = 16,
  parameter int DEPTH  = 16,
  parameter int NMATCH = 3,
  localparam int CFGW  = 2 * NMATCH,
  localparam int CNTW  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_en,
  input  logic              dbg_act,
  input  logic              secure,
  input  logic [NMATCH-1:0] match_i,
  input  logic [DW-1:0]     bus_word,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFGW-1:0]   cfg_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic [CNTW-1:0]   trace_cnt,
  output logic              armed,
  output logic [1:0]        state,
  output logic              trig,
  output logic              bkpt_req,
  output logic              swi_req,
  output logic [3:0]        mode_allow
);
  allow_t allow_q;
  logic   armed_q, align_end_q;
  logic   bkpt_q, swi_q;
  logic   ctrl_wr, arm_go, in_final, enter_final, cap, full_stop, stop;

  dbg_mode_qual u_qual (
    .clk, .rst, .dbg_en, .dbg_act, .secure, .allow_q
  );

  dbg_seq #(.NMATCH(NMATCH)) u_seq (
    .clk, .rst,
    .armed       (armed_q),
    .match_en    (allow_q.match),
    .match_i,
    .tbl_we      (cfg_we && cfg_sel != SEL_CTRL),
    .tbl_idx     (cfg_sel - 2'd1),
    .tbl_data    (cfg_data),
    .state_q     (state),
    .enter_final,
    .trig_q      (trig)
  );

  assign ctrl_wr   = cfg_we && (cfg_sel == SEL_CTRL);
  assign arm_go    = ctrl_wr && cfg_data[0] && !armed_q;
  assign in_final  = (state == ST_FINAL);
  assign cap       = armed_q && allow_q.trace && (align_end_q ? !in_final : in_final);
  assign full_stop = !align_end_q && cap && (trace_cnt == CNTW'(DEPTH - 1));
  assign stop      = align_end_q ? enter_final
                                 : (full_stop || (enter_final && !allow_q.trace));

  dbg_trace_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk, .rst,
    .clr        (arm_go),
    .cap,
    .wdata      (bus_word),
    .rd_req     (rd_en && !armed_q),
    .rd_data_q  (rd_data),
    .rd_valid_q (rd_valid),
    .cnt_q      (trace_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q     <= 1'b0;
      align_end_q <= 1'b0;
    end else if (ctrl_wr) begin
      armed_q     <= cfg_data[0];
      align_end_q <= cfg_data[1];
    end else if (armed_q && stop) begin
      armed_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bkpt_q <= 1'b0;
      swi_q  <= 1'b0;
    end else begin
      bkpt_q <= enter_final && allow_q.bkpt && dbg_en;
      swi_q  <= enter_final && allow_q.bkpt && !dbg_en;
    end
  end

  assign armed      = armed_q;
  assign bkpt_req   = bkpt_q;
  assign swi_req    = swi_q;
  assign mode_allow = allow_q;

  // R9
  bkpt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bkpt_q && swi_q));
  // R9
  bkpt_with_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (bkpt_q || swi_q) |-> trig);
  // R10
  no_trace_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!allow_q.trace && !arm_go) |=> $stable(trace_cnt));
  // R11
  active_keeps_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !allow_q.match && !ctrl_wr) |=> armed_q);
endmodule

// File: tb/test_dbg_trig_seq.sv
module test_dbg_trig_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_en = 1'b1, dbg_act = 1'b0, secure = 1'b0;
  logic [2:0]  match_i = '0;
  logic [15:0] bus_word = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [5:0]  cfg_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [4:0]  trace_cnt;
  logic        armed, trig, bkpt_req, swi_req;
  logic [1:0]  state;
  logic [3:0]  mode_allow;

  int errors = 0;
  int checks = 0;
  int rd_seen = 0;
  logic [15:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trig_seq i_dbg_trig_seq (
    .clk, .rst, .dbg_en, .dbg_act, .secure, .match_i, .bus_word,
    .cfg_we, .cfg_sel, .cfg_data, .rd_en, .rd_data, .rd_valid,
    .trace_cnt, .armed, .state, .trig, .bkpt_req, .swi_req, .mode_allow
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected trace words as read data appears
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      rd_seen++;
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected read", int'(rd_data), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R7 read order", int'(rd_data), int'(e));
      end
    end
  end

  task automatic step(input logic [2:0] m, input logic [15:0] w, input bit push, input bit re);
    match_i  = m;
    bus_word = w;
    rd_en    = re;
    if (push) begin
      exp_q.push_back(w);
      if (exp_q.size() > 16) void'(exp_q.pop_front());
    end
    @(negedge clk);
    match_i = '0;
    rd_en   = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [5:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain(input int exp_n);
    rd_seen = 0;
    for (int i = 0; i < exp_n + 2; i++) step(3'b000, 16'h0, 1'b0, 1'b1);
    repeat (2) step(3'b000, 16'h0, 1'b0, 1'b0);
    check(rd_seen == exp_n, "R7 read count", rd_seen, exp_n);
    check(exp_q.size() == 0, "R7 scoreboard empty", exp_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(state == 2'd0 && !armed && trace_cnt == 0, "R1 reset state", {armed, state}, 0);
    check(!trig && !bkpt_req && !swi_req && !rd_valid, "R1 reset pulses",
          {trig, bkpt_req, swi_req, rd_valid}, 0);
    rst = 1'b0;
    step(3'b000, 16'h0, 1'b0, 1'b0);
    // R8 enabled, inactive, not secure
    check(mode_allow == 4'b1111, "R8 allow all", mode_allow, 4'b1111);

    // table: s0 {m2->3,m1->2,m0->1}, s1 {3,0,2}, s2 {0,0,3}
    cfg(2'd1, 6'b11_10_01);
    cfg(2'd2, 6'b11_00_10);
    cfg(2'd3, 6'b00_00_11);
    // R4 disarmed matches ignored
    step(3'b100, 16'h0, 1'b0, 1'b0);
    check(state == 2'd0, "R4 ignored while disarmed", state, 0);

    // ---- end-aligned session
    cfg(2'd0, 6'b000011);
    check(armed == 1'b1 && trace_cnt == 0, "R12 armed and cleared", {armed, trace_cnt}, 6'h20);
    step(3'b110, 16'h1000, 1'b1, 1'b0);
    // R2 match1 beats match2 from state 0
    check(state == 2'd2, "R2 priority m1 over m2", state, 2);
    for (int k = 1; k <= 20; k++) step(3'b000, 16'h1000 + 16'(k), 1'b1, 1'b0);
    step(3'b101, 16'h10ff, 1'b1, 1'b0);
    // R2 match0 beats match2 from state 2
    check(state == 2'd3, "R2 priority m0 over m2", state, 3);
    check(trig == 1'b1, "R3 trigger pulse", trig, 1);
    check(bkpt_req == 1'b1 && swi_req == 1'b0, "R9 debug breakpoint", {bkpt_req, swi_req}, 2);
    check(armed == 1'b0, "R5 end-aligned disarm", armed, 0);
    check(trace_cnt == 5'd16, "R5 newest 16 kept", trace_cnt, 16);
    step(3'b000, 16'h0, 1'b0, 1'b0);
    check(trig == 1'b0 && bkpt_req == 1'b0, "R3 single-cycle trigger", {trig, bkpt_req}, 0);
    check(state == 2'd0, "R4 return to state 0", state, 0);
    drain(16);

    // ---- begin-aligned session, debug mode disabled
    dbg_en = 1'b0;
    repeat (2) step(3'b000, 16'h0, 1'b0, 1'b0);
    check(mode_allow == 4'b1111, "R8 not-enabled row", mode_allow, 4'b1111);
    cfg(2'd0, 6'b000001);
    check(trace_cnt == 0, "R12 arm clears count", trace_cnt, 0);
    step(3'b100, 16'h2fff, 1'b0, 1'b0);
    check(state == 2'd3 && trig, "R3 direct to final", {trig, state}, 3'b111);
    check(swi_req == 1'b1 && bkpt_req == 1'b0, "R9 software breakpoint", {bkpt_req, swi_req}, 1);
    check(armed == 1'b1, "R6 still armed at trigger", armed, 1);
    for (int k = 0; k < 16; k++) begin
      step((k == 4) ? 3'b001 : 3'b000, 16'h2000 + 16'(k), 1'b1, 1'b0);
      if (k == 4) check(state == 2'd3, "R3 held in final", state, 3);
    end
    check(armed == 1'b0 && trace_cnt == 5'd16, "R6 full then disarm", {armed, trace_cnt}, 16);
    drain(16);

    // ---- secure session
    dbg_en = 1'b1; secure = 1'b1;
    repeat (2) step(3'b000, 16'h0, 1'b0, 1'b0);
    check(mode_allow == 4'b0111, "R8 secure row", mode_allow, 4'b0111);
    cfg(2'd0, 6'b000011);
    repeat (3) step(3'b000, 16'h3333, 1'b0, 1'b0);
    step(3'b100, 16'h3334, 1'b0, 1'b0);
    check(trig && bkpt_req, "R10 breakpoint while secure", {trig, bkpt_req}, 3);
    check(trace_cnt == 0, "R10 no capture while secure", trace_cnt, 0);
    step(3'b000, 16'h0, 1'b0, 1'b0);

    // ---- debug-active while armed
    secure = 1'b0;
    step(3'b000, 16'h0, 1'b0, 1'b0);
    cfg(2'd0, 6'b000011);
    step(3'b010, 16'h0, 1'b0, 1'b0);
    check(state == 2'd2, "R2 state0 m1 to 2", state, 2);
    dbg_act = 1'b1;
    step(3'b000, 16'h0, 1'b0, 1'b0);
    check(mode_allow == 4'b0000, "R8 active row", mode_allow, 0);
    step(3'b001, 16'h0, 1'b0, 1'b0);
    check(armed == 1'b1 && state == 2'd2, "R11 armed and frozen", {armed, state}, 3'b110);
    dbg_act = 1'b0;
    step(3'b000, 16'h0, 1'b0, 1'b0);
    step(3'b001, 16'h0, 1'b0, 1'b0);
    check(state == 2'd3 && trig && bkpt_req, "R11 resumes after active", {trig, state}, 3'b111);
    step(3'b000, 16'h0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule